// File: doc/BRIEF.md
# Erase Region Mapper and Block Eraser

This block keeps a short list of flash erase regions, each described by how many blocks it holds and how large one block is. Regions are packed back to back starting at byte 0, so every region begins where the one before it ends. From that list the block serves the per-region four-byte entries that a flash query table places after its fixed header. It also serves the number of configured regions that the table reports.

When an erase is requested at a byte offset, the block picks the earliest region whose end lies above the offset. It rounds the offset down to that region's power-of-two block size. It then writes all-ones words over exactly one block through a word-wide memory write port, one word per clock. With an empty region list the whole device is filled instead. An offset past the last region finishes with no writes.

The fill sequencer has three states. FS_IDLE waits for a request. An accepted request moves it to FS_FILL, or straight to FS_DONE when there is nothing to write. FS_FILL writes one word per cycle and moves to FS_DONE after its last word. FS_DONE raises the done pulse and returns to FS_IDLE on the next clock.

Top module: `erase_region_engine`

## Requirements
- R1: After reset, busy, done, mem_we and cfg_err are low and region_count is 0.
- R2: An accepted configuration write (cfg_we) appends one region after the existing ones and raises region_count by one. The list holds at most MAX_REGIONS (4) entries, and a write to a full list is rejected.
- R3: A configuration write whose block count exceeds 65536, or whose block size exceeds 16776960 (65535 × 256) bytes, is rejected. A rejected write sets cfg_err and leaves the list unchanged. The next accepted write clears cfg_err.
- R4: desc_data returns the byte at desc_addr = 4·i + b for region i. Bytes b=0 and b=1 are (block count − 1) as a little-endian 16-bit value. Bytes b=2 and b=3 are (block size / 256) as a little-endian 16-bit value. Bytes of unconfigured regions read 0.
- R5: Region 0 starts at 0. Region i starts at the end of region i−1. Each region ends at its start plus block count × block size.
- R6: An erase selects the first region, in list order, whose end is greater than the offset. It clears the offset bits below that region's block size and writes 0xFF… to every word of that one block. Writes are one per clock, in ascending word addresses (byte address / WORD_BYTES).
- R7: With no regions configured, an erase writes every word of the device, word addresses 0 to 2^ADDR_W / WORD_BYTES − 1.
- R8: An offset at or beyond the last region's end produces no writes, and done still pulses.
- R9: busy is high from the cycle after an accepted request through the done cycle. done is high for exactly one cycle, and busy is low in the cycle after it.
- R10: erase_req while busy has no effect: no extra writes and no change to the running fill.
- R11: cfg_clear empties the list (region_count 0) and clears cfg_err.
- R12: A configuration write in the same cycle as an accepted erase request does not affect that erase. The erase uses the list as it stood before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Append a region |
| cfg_clear | input | 1 | Empty the region list |
| cfg_blocks | input | 17 | Block count of the region being appended |
| cfg_size | input | 25 | Block size in bytes (power of two) |
| cfg_err | output | 1 | Last configuration write was rejected |
| region_count | output | 3 | Number of configured regions |
| desc_addr | input | 4 | Byte index into the region descriptors |
| desc_data | output | 8 | Descriptor byte |
| erase_req | input | 1 | Start an erase |
| erase_offset | input | 12 | Byte offset of the erase |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 32 | Memory write data (all ones) |

## Verification
A region append and an erase request can land on the same clock edge. In that case the owning-region search must see the list from before the append. The bench provokes this by pulsing cfg_we together with erase_req at an offset that lies just past the current last region, inside the region being added. The scoreboard expects zero writes and a single done pulse. After that, region_count must show the append took effect, and a repeat erase at the same offset must write the new region's block.

// File: rtl/ere_pkg.sv
`timescale 1ns/1ps
package ere_pkg;
    localparam int BLK_W = 17;
    localparam int SZ_W  = 25;
    localparam int EXT_W = BLK_W + SZ_W;
    localparam logic [BLK_W-1:0] BLK_MAX = 17'd65536;
    localparam logic [SZ_W-1:0]  SZ_MAX  = 25'd16776960;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_FILL,
        FS_DONE
    } fill_state_e;
endpackage

// File: rtl/ere_region_table.sv
`timescale 1ns/1ps
module ere_region_table
    import ere_pkg::*;
#(
    parameter int MAX_REGIONS = 4,
    parameter int CNT_W = $clog2(MAX_REGIONS + 1),
    parameter int DA_W  = $clog2(MAX_REGIONS * 4)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic                                 cfg_clear,
    input  logic [BLK_W-1:0]                     cfg_blocks,
    input  logic [SZ_W-1:0]                      cfg_size,
    output logic                                 cfg_err,
    output logic [CNT_W-1:0]                     region_count,
    output logic [MAX_REGIONS-1:0][EXT_W-1:0]    end_o,
    output logic [MAX_REGIONS-1:0][SZ_W-1:0]     size_o,
    input  logic [DA_W-1:0]                      desc_addr,
    output logic [7:0]                           desc_data
);
    logic [MAX_REGIONS-1:0][BLK_W-1:0] blk_q;
    logic [MAX_REGIONS-1:0][SZ_W-1:0]  size_q;
    logic [CNT_W-1:0]                  count_q;
    logic                              err_q;
    logic                              reject;
    logic [EXT_W-1:0]                  acc;

    assign reject = (cfg_blocks > BLK_MAX) || (cfg_size > SZ_MAX) ||
                    (count_q == CNT_W'(MAX_REGIONS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            err_q   <= 1'b0;
        end else if (cfg_clear) begin
            count_q <= '0;
            err_q   <= 1'b0;
        end else if (cfg_we) begin
            err_q <= reject;
            if (!reject) count_q <= count_q + 1'b1;
        end
    end

    for (genvar i = 0; i < MAX_REGIONS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blk_q[i]  <= '0;
                size_q[i] <= '0;
            end else if (cfg_we && !cfg_clear && !reject && count_q == CNT_W'(i)) begin
                blk_q[i]  <= cfg_blocks;
                size_q[i] <= cfg_size;
            end
        end
    end

    // Back-to-back layout: each end accumulates the spans before it.
    always_comb begin
        acc = '0;
        for (int i = 0; i < MAX_REGIONS; i++) begin
            acc      = acc + EXT_W'(blk_q[i]) * EXT_W'(size_q[i]);
            end_o[i] = acc;
        end
    end

    always_comb begin
        desc_data = '0;
        for (int i = 0; i < MAX_REGIONS; i++) begin
            if (desc_addr[DA_W-1:2] == (DA_W-2)'(i) && CNT_W'(i) < count_q) begin
                case (desc_addr[1:0])
                    2'd0:    desc_data = 8'(blk_q[i] - 1'b1);
                    2'd1:    desc_data = 8'((blk_q[i] - 1'b1) >> 8);
                    2'd2:    desc_data = 8'(size_q[i] >> 8);
                    default: desc_data = 8'(size_q[i] >> 16);
                endcase
            end
        end
    end

    assign size_o       = size_q;
    assign region_count = count_q;
    assign cfg_err      = err_q;

    // R2
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_count <= CNT_W'(MAX_REGIONS));

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_clear && cfg_blocks > BLK_MAX) |=> (cfg_err && $stable(region_count)));

    // R11
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> (region_count == '0 && !cfg_err));
endmodule

// File: rtl/ere_lookup.sv
`timescale 1ns/1ps
module ere_lookup
    import ere_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int WORD_BYTES  = 4,
    parameter int MAX_REGIONS = 4,
    parameter int CNT_W       = $clog2(MAX_REGIONS + 1),
    parameter int WB_LOG      = $clog2(WORD_BYTES),
    parameter int WADDR_W     = ADDR_W - WB_LOG
) (
    input  logic [ADDR_W-1:0]                    offset,
    input  logic [CNT_W-1:0]                     count,
    input  logic [MAX_REGIONS-1:0][EXT_W-1:0]    end_i,
    input  logic [MAX_REGIONS-1:0][SZ_W-1:0]     size_i,
    output logic [WADDR_W-1:0]                   base_word,
    output logic [SZ_W-1:0]                      words
);
    localparam logic [SZ_W-1:0] DEV_WORDS = SZ_W'(1) << WADDR_W;

    logic found;

    always_comb begin
        found     = 1'b0;
        base_word = '0;
        words     = '0;
        if (count == '0) begin
            words = DEV_WORDS;
        end else begin
            for (int i = 0; i < MAX_REGIONS; i++) begin
                if (!found && CNT_W'(i) < count && EXT_W'(offset) < end_i[i]) begin
                    found     = 1'b1;
                    base_word = offset[ADDR_W-1:WB_LOG] &
                                ~WADDR_W'((size_i[i] - 1'b1) >> WB_LOG);
                    words     = size_i[i] >> WB_LOG;
                    if (words == '0) words = SZ_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ere_fill_seq.sv
`timescale 1ns/1ps
module ere_fill_seq
    import ere_pkg::*;
#(
    parameter int WADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WADDR_W-1:0] base_word,
    input  logic [SZ_W-1:0]    words,
    output logic               busy,
    output logic               done,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr
);
    fill_state_e        state_q, state_d;
    logic [WADDR_W-1:0] addr_q;
    logic [SZ_W-1:0]    remain_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: if (start) state_d = (words == '0) ? FS_DONE : FS_FILL;
            FS_FILL: if (remain_q == SZ_W'(1)) state_d = FS_DONE;
            FS_DONE: state_d = FS_IDLE;
            default: state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FS_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FS_IDLE && start) begin
                addr_q   <= base_word;
                remain_q <= words;
            end else if (state_q == FS_FILL) begin
                addr_q   <= addr_q + 1'b1;
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy     = (state_q != FS_IDLE);
        mem_we   = (state_q == FS_FILL);
        done     = (state_q == FS_DONE);
        mem_addr = addr_q;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && start) |=> (remain_q == $past(remain_q) - 1'b1));
endmodule

// File: rtl/erase_region_engine.sv
`timescale 1ns/1ps
module erase_region_engine
    import ere_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int WORD_BYTES  = 4,
    parameter int MAX_REGIONS = 4,
    parameter int CNT_W       = $clog2(MAX_REGIONS + 1),
    parameter int DA_W        = $clog2(MAX_REGIONS * 4),
    parameter int WADDR_W     = ADDR_W - $clog2(WORD_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic                    cfg_clear,
    input  logic [BLK_W-1:0]        cfg_blocks,
    input  logic [SZ_W-1:0]         cfg_size,
    output logic                    cfg_err,
    output logic [CNT_W-1:0]        region_count,
    input  logic [DA_W-1:0]         desc_addr,
    output logic [7:0]              desc_data,
    input  logic                    erase_req,
    input  logic [ADDR_W-1:0]       erase_offset,
    output logic                    busy,
    output logic                    done,
    output logic                    mem_we,
    output logic [WADDR_W-1:0]      mem_addr,
    output logic [WORD_BYTES*8-1:0] mem_wdata
);
    logic [MAX_REGIONS-1:0][EXT_W-1:0] region_end;
    logic [MAX_REGIONS-1:0][SZ_W-1:0]  region_size;
    logic [WADDR_W-1:0]                hit_base;
    logic [SZ_W-1:0]                   hit_words;

    ere_region_table #(.MAX_REGIONS(MAX_REGIONS), .CNT_W(CNT_W), .DA_W(DA_W)) table_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_clear(cfg_clear),
        .cfg_blocks(cfg_blocks), .cfg_size(cfg_size), .cfg_err(cfg_err),
        .region_count(region_count), .end_o(region_end), .size_o(region_size),
        .desc_addr(desc_addr), .desc_data(desc_data)
    );

    ere_lookup #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .MAX_REGIONS(MAX_REGIONS),
                 .CNT_W(CNT_W), .WADDR_W(WADDR_W)) lookup_i (
        .offset(erase_offset), .count(region_count), .end_i(region_end),
        .size_i(region_size), .base_word(hit_base), .words(hit_words)
    );

    ere_fill_seq #(.WADDR_W(WADDR_W)) fill_i (
        .clk(clk), .rst_n(rst_n), .start(erase_req), .base_word(hit_base),
        .words(hit_words), .busy(busy), .done(done), .mem_we(mem_we),
        .mem_addr(mem_addr)
    );

    assign mem_wdata = '1;
endmodule

// File: tb/erase_region_engine_tb_top.sv
`timescale 1ns/1ps
module erase_region_engine_tb_top;
    import ere_pkg::*;
    localparam int ADDR_W = 12;
    localparam int WADDR_W = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_clear = 1'b0, cfg_err;
    logic [BLK_W-1:0] cfg_blocks = '0;
    logic [SZ_W-1:0]  cfg_size = '0;
    logic [2:0] region_count;
    logic [3:0] desc_addr = '0;
    logic [7:0] desc_data;
    logic erase_req = 1'b0;
    logic [ADDR_W-1:0] erase_offset = '0;
    logic busy, done, mem_we;
    logic [WADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;

    erase_region_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_clear(cfg_clear),
        .cfg_blocks(cfg_blocks), .cfg_size(cfg_size), .cfg_err(cfg_err),
        .region_count(region_count), .desc_addr(desc_addr), .desc_data(desc_data),
        .erase_req(erase_req), .erase_offset(erase_offset), .busy(busy), .done(done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [WADDR_W-1:0] exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every memory write.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done) done_cnt++;
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "write with nothing expected", mem_addr, 0);
                end else begin
                    logic [WADDR_W-1:0] e;
                    e = exp_q.pop_front();
                    check(mem_addr == e, "R6", "write word address", mem_addr, e);
                    check(mem_wdata == 32'hFFFF_FFFF, "R6", "write data", mem_wdata, 32'hFFFF_FFFF);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic cfg_write(input int blk, input int sz);
        step();
        cfg_blocks = BLK_W'(blk);
        cfg_size = SZ_W'(sz);
        cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic read_desc(input int a, input int exp, input string req);
        desc_addr = 4'(a);
        #1;
        check(desc_data == 8'(exp), req, "descriptor byte", desc_data, exp);
    endtask

    // Driver: pushes the expected word addresses, fires the request,
    // optionally pokes a second request mid-fill or appends a region in the same cycle.
    task automatic do_erase(input int off, input int base, input int n, input string req,
                            input int poke_off, input bit with_cfg);
        int d0;
        int k;
        d0 = done_cnt;
        for (int j = 0; j < n; j++) exp_q.push_back(WADDR_W'(base + j));
        step();
        erase_offset = ADDR_W'(off);
        erase_req = 1'b1;
        cfg_we = with_cfg;
        step();
        erase_req = 1'b0;
        cfg_we = 1'b0;
        check(busy == 1'b1, "R9", "busy after request", busy, 1);
        k = 0;
        while (done_cnt == d0 && k < 5000) begin
            if (poke_off >= 0 && k == 3) begin
                erase_offset = ADDR_W'(poke_off);
                erase_req = 1'b1;
            end else begin
                erase_req = 1'b0;
            end
            step();
            k++;
        end
        erase_req = 1'b0;
        check(done == 1'b1, req, "done pulse seen", done, 1);
        step();
        check(busy == 1'b0, "R9", "busy low after done", busy, 0);
        check(done_cnt == d0 + 1, "R9", "single done pulse", done_cnt - d0, 1);
        repeat (4) step();
        check(exp_q.size() == 0, req, "writes remaining", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(busy == 0 && done == 0 && mem_we == 0, "R1", "idle outputs", {busy, done, mem_we}, 0);
        check(region_count == 0, "R1", "region count", region_count, 0);
        check(cfg_err == 0, "R1", "error flag", cfg_err, 0);

        // R2: three regions, laid out back to back (R5)
        cfg_write(4, 256);
        check(region_count == 1, "R2", "count after first", region_count, 1);
        cfg_write(2, 1024);
        cfg_write(1, 512);
        check(region_count == 3 && cfg_err == 0, "R2", "count after third", region_count, 3);

        // R4 descriptors
        read_desc(0, 3, "R4");
        read_desc(1, 0, "R4");
        read_desc(2, 1, "R4");
        read_desc(3, 0, "R4");
        read_desc(4, 1, "R4");
        read_desc(6, 4, "R4");
        read_desc(12, 0, "R4");

        // R5 / R6 erases in each region
        do_erase(336, 64, 64, "R6", -1, 1'b0);
        do_erase(2000, 256, 256, "R5", -1, 1'b0);
        do_erase(3100, 768, 128, "R5", -1, 1'b0);

        // R8 beyond last region
        do_erase(3600, 0, 0, "R8", -1, 1'b0);

        // R10 request during fill ignored
        do_erase(10, 0, 64, "R10", 700, 1'b0);

        // R3 limit rejections
        cfg_write(65537, 256);
        check(cfg_err == 1, "R3", "count limit error", cfg_err, 1);
        check(region_count == 3, "R3", "count unchanged", region_count, 3);
        cfg_write(1, 16777216);
        check(cfg_err == 1 && region_count == 3, "R3", "size limit error", {cfg_err, region_count}, 4'hB);

        // R12 append in the same cycle as an erase request
        cfg_blocks = BLK_W'(1);
        cfg_size = SZ_W'(256);
        do_erase(3600, 0, 0, "R12", -1, 1'b1);
        check(region_count == 4, "R12", "append took effect", region_count, 4);
        check(cfg_err == 0, "R3", "accepted write clears error", cfg_err, 0);
        do_erase(3600, 896, 64, "R12", -1, 1'b0);

        // R2 full list
        cfg_write(1, 256);
        check(cfg_err == 1 && region_count == 4, "R2", "fifth region rejected", {cfg_err, region_count}, 4'hC);

        // R11 clear
        step();
        cfg_clear = 1'b1;
        step();
        cfg_clear = 1'b0;
        check(region_count == 0 && cfg_err == 0, "R11", "cleared", {cfg_err, region_count}, 0);
        read_desc(0, 0, "R4");

        // R7 whole device
        do_erase(5, 0, 1024, "R7", -1, 1'b0);

        // R3 limits are inclusive
        cfg_write(65536, 16776960);
        check(cfg_err == 0 && region_count == 1, "R3", "limit values accepted", {cfg_err, region_count}, 1);
        read_desc(0, 8'hFF, "R4");
        read_desc(1, 8'hFF, "R4");
        read_desc(2, 8'hFF, "R4");
        read_desc(3, 8'hFF, "R4");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule